// File: doc/BRIEF.md
# Memory Barrier Access Checker

This block guards the address space of a small processor with a table of barrier regions. Each region is an inclusive address range [left, right]. For every access the processor announces, the checker compares the current instruction pointer with the target address against every active region in parallel. It then returns a verdict one cycle later. A blocked access does not stop the processor. It produces a one-cycle fault pulse that carries a fixed access-fault interrupt identifier, which the interrupt logic can dispatch.

Reads, writes and jumps must stay on one side of every region boundary. Sequential advances of the instruction pointer are the only way to move into or out of a region. Entry is allowed by stepping from the address just before the left edge onto the left edge. Exit is allowed by stepping from the right edge to the address after it. Control transfers made by interrupt dispatch skip the checks entirely.

A management port adds and removes barriers. A new barrier must nest cleanly with the existing ones. It cannot be placed by code that is already confined by an overlapping barrier. When a barrier is created, it records a removal point. Only a removal request issued from that point takes the barrier away. A refused request raises an error flag and leaves the table untouched.

Top module: `mem_barrier_guard`

## Requirements
- R1: For req_kind codes 0 (read), 1 (write), 2 (jump) and 5 to 7 (treated as a read), the access is allowed exactly when, for every valid barrier, req_ip and req_tgt are both inside [left, right] or both outside it (bounds inclusive).
- R2: For req_kind 3 (sequential step), a valid barrier whose membership differs between req_ip and req_tgt blocks the step unless one of two edge moves applies. The first is entry: req_ip+1 == left and req_tgt == left. The second is exit: req_ip == right and req_tgt == right+1. Both use arithmetic without wrap-around. A step that crosses no barrier is allowed.
- R3: req_kind 4 (interrupt dispatch transfer) is always allowed, whatever the table holds.
- R4: chk_valid is high exactly one cycle after req_valid. In that cycle, flt_pulse equals the inverse of chk_allow, and flt_id equals FAULT_ID while flt_pulse is high and is 0 otherwise.
- R5: An add request (mgmt_del = 0) to an empty table succeeds for any range with left <= right and a removal point outside the range.
- R6: An add request with mgmt_left > mgmt_right, or with mgmt_rmpt inside [mgmt_left, mgmt_right], is rejected.
- R7: An add request whose range partially overlaps a valid barrier is rejected. A partial overlap means the ranges intersect and neither contains the other.
- R8: An add request is rejected when mgmt_ip lies inside a valid barrier that intersects the new range.
- R9: An add request is rejected when all SLOTS barriers are valid.
- R10: A remove request (mgmt_del = 1) deletes every valid barrier whose removal point equals mgmt_ip. If no barrier matches, the request is rejected.
- R11: mgmt_done is high exactly one cycle after mgmt_valid, and mgmt_err is high in that cycle exactly when the request was rejected. A rejected request leaves every access verdict unchanged.
- R12: After reset the table is empty, so every access is allowed, and chk_valid, flt_pulse, mgmt_done and mgmt_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_kind | input | 3 | Access kind code (see R1 to R3) |
| req_ip | input | ADDR_W | Current instruction pointer |
| req_tgt | input | ADDR_W | Target address, or the next instruction pointer for a step |
| mgmt_valid | input | 1 | Management request present |
| mgmt_del | input | 1 | 0 = add barrier, 1 = remove barrier |
| mgmt_ip | input | ADDR_W | Address of the code issuing the request |
| mgmt_left | input | ADDR_W | Left edge of the new barrier |
| mgmt_right | input | ADDR_W | Right edge of the new barrier |
| mgmt_rmpt | input | ADDR_W | Removal point of the new barrier |
| chk_valid | output | 1 | Verdict present |
| chk_allow | output | 1 | Access allowed |
| flt_pulse | output | 1 | Access fault, used as an interrupt request |
| flt_id | output | FLT_ID_W | Interrupt identifier of the fault |
| mgmt_done | output | 1 | Management request finished |
| mgmt_err | output | 1 | Management request rejected |

## Verification
The hardest cases to reach from the ports are a full table and the nesting refusals. In those cases the requesting code sits inside one barrier while the new range touches it, or the new range straddles an edge. Each of these cases needs a particular sequence of accepted adds first. The stimulus builds nested and disjoint barriers step by step, fills the table, and then issues refused adds and non-matching removals. After each change to the table, the bench sweeps every combination of kind, instruction pointer and target over the low 32 addresses. This shows through the verdicts that the table changed only as intended.

// File: rtl/mbg_pkg.sv
package mbg_pkg;
   typedef enum logic [2:0] {
      MBG_RD   = 3'd0,
      MBG_WR   = 3'd1,
      MBG_JMP  = 3'd2,
      MBG_STEP = 3'd3,
      MBG_IRQ  = 3'd4
   } mbg_kind_e;
endpackage

// File: rtl/mbg_slot_cmp.sv
module mbg_slot_cmp #(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  logic [ADDR_W-1:0] rmpt,
   input  logic [ADDR_W-1:0] req_ip,
   input  logic [ADDR_W-1:0] req_tgt,
   input  logic [ADDR_W-1:0] mgmt_ip,
   input  logic [ADDR_W-1:0] new_lo,
   input  logic [ADDR_W-1:0] new_hi,
   output logic              sep,
   output logic              edge_ok,
   output logic              mip_in,
   output logic              ovl,
   output logic              partial,
   output logic              rm_hit
);
   localparam int WW = ADDR_W + 1;

   logic ip_in, tgt_in, holds_new, new_holds;
   logic [WW-1:0] ip_w, tgt_w, lo_w, hi_w;

   assign ip_w  = {1'b0, req_ip};
   assign tgt_w = {1'b0, req_tgt};
   assign lo_w  = {1'b0, lo};
   assign hi_w  = {1'b0, hi};

   assign ip_in  = (req_ip  >= lo) && (req_ip  <= hi);
   assign tgt_in = (req_tgt >= lo) && (req_tgt <= hi);
   assign sep    = ip_in ^ tgt_in;

   // entry over the left edge or exit over the right edge, no wrap
   assign edge_ok = ((ip_w + WW'(1) == lo_w) && (tgt_w == lo_w)) ||
                    ((ip_w == hi_w) && (tgt_w == hi_w + WW'(1)));

   assign mip_in    = (mgmt_ip >= lo) && (mgmt_ip <= hi);
   assign ovl       = !((new_hi < lo) || (new_lo > hi));
   assign holds_new = (lo <= new_lo) && (new_hi <= hi);
   assign new_holds = (new_lo <= lo) && (hi <= new_hi);
   assign partial   = ovl && !holds_new && !new_holds;
   assign rm_hit    = (rmpt == mgmt_ip);
endmodule

// File: rtl/mbg_free_pick.sv
module mbg_free_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] used,
   output logic [N-1:0] pick,
   output logic         full
);
   always_comb begin
      pick = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!used[i]) begin
            pick    = '0;
            pick[i] = 1'b1;
         end
      end
   end

   assign full = &used;
endmodule

// File: rtl/mem_barrier_guard.sv
module mem_barrier_guard
   import mbg_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int SLOTS    = 4,
   parameter int FLT_ID_W = 4,
   parameter int FAULT_ID = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [2:0]          req_kind,
   input  logic [ADDR_W-1:0]   req_ip,
   input  logic [ADDR_W-1:0]   req_tgt,
   input  logic                mgmt_valid,
   input  logic                mgmt_del,
   input  logic [ADDR_W-1:0]   mgmt_ip,
   input  logic [ADDR_W-1:0]   mgmt_left,
   input  logic [ADDR_W-1:0]   mgmt_right,
   input  logic [ADDR_W-1:0]   mgmt_rmpt,
   output logic                chk_valid,
   output logic                chk_allow,
   output logic                flt_pulse,
   output logic [FLT_ID_W-1:0] flt_id,
   output logic                mgmt_done,
   output logic                mgmt_err
);
   localparam logic [FLT_ID_W-1:0] FID = FLT_ID_W'(FAULT_ID);

   if (ADDR_W < 2) begin : g_bad_aw
      $error("ADDR_W must be at least 2");
   end
   if (SLOTS < 1) begin : g_bad_slots
      $error("SLOTS must be at least 1");
   end
   if (FAULT_ID < 0 || FAULT_ID >= (1 << FLT_ID_W)) begin : g_bad_fid
      $error("FAULT_ID does not fit in FLT_ID_W bits");
   end

   logic [SLOTS-1:0]  tbl_v;
   logic [ADDR_W-1:0] tbl_lo [SLOTS];
   logic [ADDR_W-1:0] tbl_hi [SLOTS];
   logic [ADDR_W-1:0] tbl_rm [SLOTS];

   logic [SLOTS-1:0] s_sep, s_edge, s_mip, s_ovl, s_part, s_rm;
   logic [SLOTS-1:0] pick;
   logic             full;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      mbg_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
         .lo      (tbl_lo[g]),
         .hi      (tbl_hi[g]),
         .rmpt    (tbl_rm[g]),
         .req_ip  (req_ip),
         .req_tgt (req_tgt),
         .mgmt_ip (mgmt_ip),
         .new_lo  (mgmt_left),
         .new_hi  (mgmt_right),
         .sep     (s_sep[g]),
         .edge_ok (s_edge[g]),
         .mip_in  (s_mip[g]),
         .ovl     (s_ovl[g]),
         .partial (s_part[g]),
         .rm_hit  (s_rm[g])
      );
   end

   mbg_free_pick #(.N(SLOTS)) u_pick (
      .used (tbl_v),
      .pick (pick),
      .full (full)
   );

   // access verdict
   mbg_kind_e kind;
   logic      allow;
   assign kind = mbg_kind_e'(req_kind);

   always_comb begin
      unique case (kind)
         MBG_IRQ:  allow = 1'b1;
         MBG_STEP: allow = ~|(tbl_v & s_sep & ~s_edge);
         default:  allow = ~|(tbl_v & s_sep);
      endcase
   end

   // management verdict
   logic             add_err, del_err, op_err, rm_in_new;
   logic [SLOTS-1:0] del_hits;

   assign rm_in_new = (mgmt_rmpt >= mgmt_left) && (mgmt_rmpt <= mgmt_right);
   assign add_err   = full || (mgmt_left > mgmt_right) || rm_in_new ||
                      (|(tbl_v & s_part)) || (|(tbl_v & s_mip & s_ovl));
   assign del_hits  = tbl_v & s_rm;
   assign del_err   = ~|del_hits;
   assign op_err    = mgmt_del ? del_err : add_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_valid <= 1'b0;
         chk_allow <= 1'b0;
         flt_pulse <= 1'b0;
         flt_id    <= '0;
         mgmt_done <= 1'b0;
         mgmt_err  <= 1'b0;
      end else begin
         chk_valid <= req_valid;
         chk_allow <= req_valid && allow;
         flt_pulse <= req_valid && !allow;
         flt_id    <= (req_valid && !allow) ? FID : '0;
         mgmt_done <= mgmt_valid;
         mgmt_err  <= mgmt_valid && op_err;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl_v <= '0;
         for (int i = 0; i < SLOTS; i++) begin
            tbl_lo[i] <= '0;
            tbl_hi[i] <= '0;
            tbl_rm[i] <= '0;
         end
      end else if (mgmt_valid && !op_err) begin
         if (mgmt_del) begin
            tbl_v <= tbl_v & ~del_hits;
         end else begin
            for (int i = 0; i < SLOTS; i++) begin
               if (pick[i]) begin
                  tbl_v[i]  <= 1'b1;
                  tbl_lo[i] <= mgmt_left;
                  tbl_hi[i] <= mgmt_right;
                  tbl_rm[i] <= mgmt_rmpt;
               end
            end
         end
      end
   end
endmodule

// File: rtl/mbg_checker.sv
module mbg_checker #(
   parameter int ADDR_W   = 8,
   parameter int FLT_ID_W = 4,
   parameter int FAULT_ID = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [2:0]          req_kind,
   input logic [ADDR_W-1:0]   req_ip,
   input logic [ADDR_W-1:0]   req_tgt,
   input logic                mgmt_valid,
   input logic                mgmt_del,
   input logic [ADDR_W-1:0]   mgmt_left,
   input logic [ADDR_W-1:0]   mgmt_right,
   input logic [ADDR_W-1:0]   mgmt_rmpt,
   input logic                chk_valid,
   input logic                chk_allow,
   input logic                flt_pulse,
   input logic [FLT_ID_W-1:0] flt_id,
   input logic                mgmt_done,
   input logic                mgmt_err
);
   p_same_point_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_kind inside {3'd0, 3'd1, 3'd2}) && (req_ip == req_tgt) |=> chk_allow);

   p_irq_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_kind == 3'd4) |=> chk_allow && !flt_pulse);

   p_verdict_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> chk_valid && (flt_pulse == !chk_allow));

   p_verdict_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !chk_valid && !flt_pulse);

   p_fault_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
      flt_pulse |-> (flt_id == FLT_ID_W'(FAULT_ID)));

   p_fault_id_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_pulse |-> (flt_id == '0));

   p_bad_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_valid && !mgmt_del &&
      ((mgmt_left > mgmt_right) || ((mgmt_rmpt >= mgmt_left) && (mgmt_rmpt <= mgmt_right)))
      |=> mgmt_err);

   p_mgmt_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_valid |=> mgmt_done);

   p_mgmt_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !mgmt_valid |=> !mgmt_done && !mgmt_err);
endmodule

bind mem_barrier_guard mbg_checker #(
   .ADDR_W   (ADDR_W),
   .FLT_ID_W (FLT_ID_W),
   .FAULT_ID (FAULT_ID)
) u_mbg_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_kind   (req_kind),
   .req_ip     (req_ip),
   .req_tgt    (req_tgt),
   .mgmt_valid (mgmt_valid),
   .mgmt_del   (mgmt_del),
   .mgmt_left  (mgmt_left),
   .mgmt_right (mgmt_right),
   .mgmt_rmpt  (mgmt_rmpt),
   .chk_valid  (chk_valid),
   .chk_allow  (chk_allow),
   .flt_pulse  (flt_pulse),
   .flt_id     (flt_id),
   .mgmt_done  (mgmt_done),
   .mgmt_err   (mgmt_err)
);

// File: tb/mem_barrier_guard_bench.sv
`timescale 1ns/1ps
module mem_barrier_guard_bench;
   localparam int AW    = 8;
   localparam int NS    = 4;
   localparam int FW    = 4;
   localparam int FID   = 3;
   localparam int SPAN  = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_kind = '0;
   logic [AW-1:0] req_ip = '0, req_tgt = '0;
   logic          mgmt_valid = 1'b0, mgmt_del = 1'b0;
   logic [AW-1:0] mgmt_ip = '0, mgmt_left = '0, mgmt_right = '0, mgmt_rmpt = '0;
   logic          chk_valid, chk_allow, flt_pulse, mgmt_done, mgmt_err;
   logic [FW-1:0] flt_id;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // bench-side barrier table
   bit m_v [NS];
   int m_l [NS];
   int m_r [NS];
   int m_rm[NS];

   always #4 clk = ~clk;

   mem_barrier_guard #(.ADDR_W(AW), .SLOTS(NS), .FLT_ID_W(FW), .FAULT_ID(FID)) u_mem_barrier_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_ip(req_ip), .req_tgt(req_tgt), .mgmt_valid(mgmt_valid), .mgmt_del(mgmt_del),
      .mgmt_ip(mgmt_ip), .mgmt_left(mgmt_left), .mgmt_right(mgmt_right), .mgmt_rmpt(mgmt_rmpt),
      .chk_valid(chk_valid), .chk_allow(chk_allow), .flt_pulse(flt_pulse), .flt_id(flt_id),
      .mgmt_done(mgmt_done), .mgmt_err(mgmt_err)
   );

   function automatic bit in_rng(int a, int l, int r);
      return (a >= l) && (a <= r);
   endfunction

   // expected verdict from R1, R2, R3
   function automatic bit exp_allow(int kind, int ip, int tgt);
      if (kind == 4) return 1'b1;
      for (int i = 0; i < NS; i++) begin
         if (m_v[i] && (in_rng(ip, m_l[i], m_r[i]) != in_rng(tgt, m_l[i], m_r[i]))) begin
            if (kind != 3) return 1'b0;
            if (!(((ip + 1 == m_l[i]) && (tgt == m_l[i])) ||
                  ((ip == m_r[i]) && (tgt == m_r[i] + 1)))) return 1'b0;
         end
      end
      return 1'b1;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic one_req(int kind, int ip, int tgt);
      bit    e;
      string tag;
      e = exp_allow(kind, ip, tgt);
      tag = (kind == 3) ? "R2" : (kind == 4) ? "R3" : "R1";
      @(negedge clk);
      req_valid = 1'b1;
      req_kind  = 3'(kind);
      req_ip    = AW'(ip);
      req_tgt   = AW'(tgt);
      @(posedge clk);
      #1;
      check(chk_valid && (chk_allow == e), tag, int'(chk_allow), int'(e));
      check((flt_pulse == !e) && (flt_id == (e ? FW'(0) : FW'(FID))),
            "R4 fault", int'(flt_id), e ? 0 : FID);
   endtask

   task automatic sweep();
      for (int k = 0; k < 8; k++)
         for (int a = 0; a < SPAN; a++)
            for (int b = 0; b < SPAN; b++)
               one_req(k, a, b);
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk);
      #1;
      check(!chk_valid && !flt_pulse, "R4 idle", int'(chk_valid), 0);
   endtask

   task automatic mgmt(bit del, int ip, int l, int r, int rm, bit exp_err, string tag);
      @(negedge clk);
      mgmt_valid = 1'b1;
      mgmt_del   = del;
      mgmt_ip    = AW'(ip);
      mgmt_left  = AW'(l);
      mgmt_right = AW'(r);
      mgmt_rmpt  = AW'(rm);
      @(posedge clk);
      #1;
      check(mgmt_done && (mgmt_err == exp_err), tag, int'(mgmt_err), int'(exp_err));
      @(negedge clk);
      mgmt_valid = 1'b0;
      @(posedge clk);
      #1;
      check(!mgmt_done && !mgmt_err, "R11 idle", int'(mgmt_done), 0);
      if (!exp_err) begin
         if (del) begin
            for (int i = 0; i < NS; i++)
               if (m_v[i] && m_rm[i] == ip) m_v[i] = 1'b0;
         end else begin
            for (int i = 0; i < NS; i++) begin
               if (!m_v[i]) begin
                  m_v[i] = 1'b1; m_l[i] = l; m_r[i] = r; m_rm[i] = rm;
                  break;
               end
            end
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NS; i++) m_v[i] = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      check(!chk_valid && !flt_pulse && !mgmt_done && !mgmt_err && flt_id == '0,
            "R12 reset outputs", int'(chk_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      sweep();                                         // R12 empty table
      mgmt(0, 0, 8, 15, 2, 1'b0, "R5 add first");
      sweep();
      mgmt(0, 9, 10, 12, 20, 1'b1, "R8 confined add");
      mgmt(0, 30, 10, 12, 20, 1'b0, "R8 outside add");
      mgmt(0, 30, 12, 20, 30, 1'b1, "R7 partial");
      mgmt(0, 30, 5, 3, 30, 1'b1, "R6 reversed");
      mgmt(0, 30, 16, 19, 17, 1'b1, "R6 rmpt inside");
      mgmt(0, 30, 20, 25, 9, 1'b0, "R5 disjoint add");
      sweep();
      mgmt(0, 30, 26, 28, 0, 1'b0, "R9 last slot");
      mgmt(0, 30, 29, 29, 3, 1'b1, "R9 full");
      mgmt(1, 5, 0, 0, 0, 1'b1, "R10 no match");
      sweep();                                         // R11 table unchanged
      mgmt(1, 9, 0, 0, 0, 1'b0, "R10 remove");
      mgmt(1, 2, 0, 0, 0, 1'b0, "R10 remove outer");
      sweep();
      mgmt(0, 30, 0, 31, 40, 1'b0, "R5 enclosing add");
      mgmt(0, 11, 11, 11, 50, 1'b1, "R8 inner confined");
      sweep();
      mgmt(1, 20, 0, 0, 0, 1'b0, "R10 remove inner");
      sweep();
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule